// File: doc/BRIEF.md
# Packet-Granular Host Bus FIFO Bridge

This block sits between a device-side processing core and an external bus controller that starts and strobes every transfer in both directions. The block never begins a bus cycle. It only raises two flags, each covering a whole packet, and then answers the strobes the controller issues. The bus is 16 bits wide, and a packet is 256 words (512 bytes) in both directions.

In the transmit direction, words strobed in by the controller go into one FIFO per channel. Each channel FIFO has its own read port toward the core. Whole packets are dealt out to the channels in turn. The space flag is decided only at a packet boundary: it is raised when the channel due for the next packet can take all of that packet, and it then stays up until the packet's last word has arrived.

In the receive direction, the core pushes samples into a single FIFO. The packet-available flag tells the controller that a complete packet can be pulled. A free-running 32-bit timestamp counter advances on every cycle of the converter-rate clock. Strobes that arrive while their flag is low leave sticky error bits set and do not change any FIFO.

Top module: `host_pkt_bridge`

## Requirements
- R1: After a synchronous reset, txSpace is 1 and rxPktAvail is 0. overrunErr, underrunErr, txRdValid, rxFull and timestamp are all 0.
- R2: Accepted transmit words are stored in channel 0 for 256 words, then in channel 1 for 256 words, and so on round-robin, wrapping from the last channel back to channel 0. A packet never straddles two channels.
- R3: At a packet boundary (word position 0), txSpace is 1 exactly when the channel due for the next packet holds no more than its depth minus 256 words. Between the first and the last word of a packet, txSpace stays 1.
- R4: A busWrStb while txSpace is 0 stores nothing and does not advance the word position. It sets overrunErr, which stays 1 until reset.
- R5: Each channel's read port shows the oldest word of that channel on txRdData (channel c in bits [16c+15:16c]) while txRdValid[c] is 1. txRdEn[c] removes that word. txRdEn on an empty channel has no effect.
- R6: At a receive packet boundary, rxPktAvail is 1 exactly when at least 256 words are buffered. It stays 1 while a packet is being read, and after the packet's last word it remains 1 only if another 256 words are held.
- R7: A busRdStb while rxPktAvail is 0 removes nothing. It sets underrunErr, which stays 1 until reset.
- R8: busRdData always shows the oldest buffered receive word, and accepted read strobes return the words in the order rxWrEn pushed them.
- R9: rxFull is 1 when the receive FIFO holds 512 words. An rxWrEn while full is ignored.
- R10: timestamp increments by one on every clock cycle after reset, modulo 2^32.
- R11: A reset in the middle of traffic empties every FIFO, returns both word positions to 0 and the round-robin to channel 0, and clears both error bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| busWrStb | input | 1 | Controller write strobe, one transmit word |
| busWrData | input | 16 | Transmit word from the controller |
| txSpace | output | 1 | A whole transmit packet may be written |
| busRdStb | input | 1 | Controller read strobe, one receive word |
| busRdData | output | 16 | Oldest receive word |
| rxPktAvail | output | 1 | A whole receive packet can be read |
| txRdEn | input | 2 | Per-channel pop toward the core |
| txRdData | output | 32 | Per-channel head word, channel c at [16c+15:16c] |
| txRdValid | output | 2 | Per-channel not-empty |
| rxWrEn | input | 1 | Core pushes one receive word |
| rxWrData | input | 16 | Receive word from the core |
| rxFull | output | 1 | Receive FIFO holds 512 words |
| overrunErr | output | 1 | Sticky: write strobe without space |
| underrunErr | output | 1 | Sticky: read strobe without packet |
| timestamp | output | 32 | Free-running cycle counter |

## Verification
Directed sequences come first.
- Four back-to-back transmit packets fill both channels. This separates correct round-robin steering from a design that fills one channel twice, and it produces the case where space is withheld.
- Draining exactly 255 and then 256 words from the blocked channel shows whether the boundary test uses a whole packet of free room or a single free word.
- A receive FIFO holding 255, then 256, then 512 words separates the packet-count rule from an ordinary not-empty flag. It also exercises the full case.

Long random runs then mix write strobes, read strobes, per-channel pops and core pushes, each at its own rate. A per-cycle model catches ordering errors, flag changes in mid-packet, and pointer changes caused by rejected strobes. A reset in the middle of traffic closes the run.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
  // Width of the channel selector carried in the strobe bundle (up to 16 channels).
  localparam int SEL_W = 4;

  typedef struct packed {
    logic             txPush;  // store busWrData into channel txSel
    logic [SEL_W-1:0] txSel;   // channel owning the current transmit packet
    logic             rxPop;   // retire the receive head word
  } hpbStrobe_t;
endpackage

// File: rtl/hpb_fifo.sv
module hpb_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 512
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [WIDTH-1:0]           pushData,
  input  logic                       pop,
  output logic [WIDTH-1:0]           headData,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [LW-1:0]    fill;
  logic             doPush, doPop;

  // Guards keep pointers intact on push-when-full or pop-when-empty.
  assign doPush = push && (fill != FULL_LVL);
  assign doPop  = pop && (fill != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  assign headData = store[rdPtr];
  assign level    = fill;
endmodule

// File: rtl/hpb_datapath.sv
module hpb_datapath
  import hpb_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_CH   = 2,
  parameter int TX_DEPTH = 512,
  parameter int RX_DEPTH = 512,
  parameter int TS_W     = 32
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  hpbStrobe_t                            strobe,
  input  logic [DATA_W-1:0]                     busWrData,
  output logic [DATA_W-1:0]                     busRdData,
  input  logic [NUM_CH-1:0]                     txRdEn,
  output logic [NUM_CH*DATA_W-1:0]              txRdData,
  output logic [NUM_CH-1:0]                     txRdValid,
  output logic [NUM_CH*$clog2(TX_DEPTH+1)-1:0]  txLevel,
  input  logic                                  rxWrEn,
  input  logic [DATA_W-1:0]                     rxWrData,
  output logic [$clog2(RX_DEPTH+1)-1:0]         rxLevel,
  output logic                                  rxFull,
  output logic [TS_W-1:0]                       timestamp
);
  localparam int TXL_W = $clog2(TX_DEPTH + 1);
  localparam int RXL_W = $clog2(RX_DEPTH + 1);
  localparam logic [RXL_W-1:0] RX_FULL_LVL = RXL_W'(RX_DEPTH);

  // One dedicated FIFO and read port per transmit channel.
  for (genvar g = 0; g < NUM_CH; g++) begin : gTxCh
    logic             chPush;
    logic [TXL_W-1:0] chLevel;

    assign chPush = strobe.txPush && (strobe.txSel == SEL_W'(g));

    hpb_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) uTxFifo (
      .clk      (clk),
      .rst      (rst),
      .push     (chPush),
      .pushData (busWrData),
      .pop      (txRdEn[g]),
      .headData (txRdData[g*DATA_W +: DATA_W]),
      .level    (chLevel)
    );

    assign txLevel[g*TXL_W +: TXL_W] = chLevel;
    assign txRdValid[g]              = (chLevel != '0);
  end

  hpb_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) uRxFifo (
    .clk      (clk),
    .rst      (rst),
    .push     (rxWrEn),
    .pushData (rxWrData),
    .pop      (strobe.rxPop),
    .headData (busRdData),
    .level    (rxLevel)
  );

  assign rxFull = (rxLevel == RX_FULL_LVL);

  logic [TS_W-1:0] tsCount;
  always_ff @(posedge clk) begin
    if (rst) tsCount <= '0;
    else     tsCount <= tsCount + 1'b1;
  end
  assign timestamp = tsCount;
endmodule

// File: rtl/hpb_control.sv
module hpb_control
  import hpb_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int PKT_WORDS = 256,
  parameter int TX_DEPTH  = 512,
  parameter int RX_DEPTH  = 512
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 busWrStb,
  input  logic                                 busRdStb,
  input  logic [NUM_CH*$clog2(TX_DEPTH+1)-1:0] txLevel,
  input  logic [$clog2(RX_DEPTH+1)-1:0]        rxLevel,
  output hpbStrobe_t                           strobe,
  output logic                                 txSpace,
  output logic                                 rxPktAvail,
  output logic                                 overrunErr,
  output logic                                 underrunErr
);
  localparam int TXL_W = $clog2(TX_DEPTH + 1);
  localparam int RXL_W = $clog2(RX_DEPTH + 1);
  localparam int CNT_W = $clog2(PKT_WORDS);
  localparam logic [CNT_W-1:0] LAST_WORD   = CNT_W'(PKT_WORDS - 1);
  localparam logic [TXL_W-1:0] TX_ROOM_MAX = TXL_W'(TX_DEPTH - PKT_WORDS);
  localparam logic [RXL_W-1:0] RX_PKT_LVL  = RXL_W'(PKT_WORDS);
  localparam logic [SEL_W-1:0] LAST_CH     = SEL_W'(NUM_CH - 1);

  logic [CNT_W-1:0] txWordPos, rxWordPos;
  logic [SEL_W-1:0] txCh;
  logic [TXL_W-1:0] curLevel;
  logic             txAccept, rxAccept;

  assign curLevel = txLevel[txCh*TXL_W +: TXL_W];

  // Flags are decided at packet boundaries and held for the packet body.
  assign txSpace    = (txWordPos != '0) || (curLevel <= TX_ROOM_MAX);
  assign rxPktAvail = (rxWordPos != '0) || (rxLevel >= RX_PKT_LVL);

  assign txAccept = busWrStb && txSpace;
  assign rxAccept = busRdStb && rxPktAvail;

  always_ff @(posedge clk) begin
    if (rst) begin
      txWordPos   <= '0;
      rxWordPos   <= '0;
      txCh        <= '0;
      overrunErr  <= 1'b0;
      underrunErr <= 1'b0;
    end else begin
      if (txAccept) begin
        if (txWordPos == LAST_WORD) begin
          txWordPos <= '0;
          txCh      <= (txCh == LAST_CH) ? '0 : txCh + 1'b1;
        end else begin
          txWordPos <= txWordPos + 1'b1;
        end
      end
      if (rxAccept) begin
        rxWordPos <= (rxWordPos == LAST_WORD) ? '0 : rxWordPos + 1'b1;
      end
      if (busWrStb && !txSpace)    overrunErr  <= 1'b1;
      if (busRdStb && !rxPktAvail) underrunErr <= 1'b1;
    end
  end

  always_comb begin
    strobe.txPush = txAccept;
    strobe.txSel  = txCh;
    strobe.rxPop  = rxAccept;
  end
endmodule

// File: rtl/host_pkt_bridge.sv
module host_pkt_bridge
  import hpb_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PKT_WORDS = 256,
  parameter int NUM_CH    = 2,
  parameter int TX_PKTS   = 2,
  parameter int RX_PKTS   = 2,
  parameter int TS_W      = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     busWrStb,
  input  logic [DATA_W-1:0]        busWrData,
  output logic                     txSpace,
  input  logic                     busRdStb,
  output logic [DATA_W-1:0]        busRdData,
  output logic                     rxPktAvail,
  input  logic [NUM_CH-1:0]        txRdEn,
  output logic [NUM_CH*DATA_W-1:0] txRdData,
  output logic [NUM_CH-1:0]        txRdValid,
  input  logic                     rxWrEn,
  input  logic [DATA_W-1:0]        rxWrData,
  output logic                     rxFull,
  output logic                     overrunErr,
  output logic                     underrunErr,
  output logic [TS_W-1:0]          timestamp
);
  localparam int TX_DEPTH = TX_PKTS * PKT_WORDS;
  localparam int RX_DEPTH = RX_PKTS * PKT_WORDS;
  localparam int TXL_W    = $clog2(TX_DEPTH + 1);
  localparam int RXL_W    = $clog2(RX_DEPTH + 1);

  hpbStrobe_t              strobe;
  logic [NUM_CH*TXL_W-1:0] txLevel;
  logic [RXL_W-1:0]        rxLevel;

  hpb_control #(
    .NUM_CH(NUM_CH), .PKT_WORDS(PKT_WORDS), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)
  ) uCtrl (
    .clk         (clk),
    .rst         (rst),
    .busWrStb    (busWrStb),
    .busRdStb    (busRdStb),
    .txLevel     (txLevel),
    .rxLevel     (rxLevel),
    .strobe      (strobe),
    .txSpace     (txSpace),
    .rxPktAvail  (rxPktAvail),
    .overrunErr  (overrunErr),
    .underrunErr (underrunErr)
  );

  hpb_datapath #(
    .DATA_W(DATA_W), .NUM_CH(NUM_CH), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .TS_W(TS_W)
  ) uData (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .txRdEn    (txRdEn),
    .txRdData  (txRdData),
    .txRdValid (txRdValid),
    .txLevel   (txLevel),
    .rxWrEn    (rxWrEn),
    .rxWrData  (rxWrData),
    .rxLevel   (rxLevel),
    .rxFull    (rxFull),
    .timestamp (timestamp)
  );
endmodule

// File: rtl/host_pkt_bridge_chk.sv
module host_pkt_bridge_chk #(
  parameter int PKT_WORDS = 256,
  parameter int TS_W      = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            busWrStb,
  input logic            busRdStb,
  input logic            txSpace,
  input logic            rxPktAvail,
  input logic            overrunErr,
  input logic            underrunErr,
  input logic [TS_W-1:0] timestamp
);
  localparam int CW = $clog2(PKT_WORDS);
  localparam logic [CW-1:0] LAST = CW'(PKT_WORDS - 1);

  // Independent tally of accepted words within a packet, built from port activity.
  logic [CW-1:0] wrSeen, rdSeen;
  logic          liveCycle, rstPrev;

  always_ff @(posedge clk) begin
    rstPrev <= rst;
    if (rst) begin
      wrSeen    <= '0;
      rdSeen    <= '0;
      liveCycle <= 1'b0;
    end else begin
      liveCycle <= 1'b1;
      if (busWrStb && txSpace)    wrSeen <= (wrSeen == LAST) ? '0 : wrSeen + 1'b1;
      if (busRdStb && rxPktAvail) rdSeen <= (rdSeen == LAST) ? '0 : rdSeen + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rstPrev === 1'b1 && !rst) begin
      assert_reset_state_R1: assert (txSpace && !rxPktAvail && !overrunErr && !underrunErr
                                     && timestamp == '0)
        else $error("reset state wrong");
    end
  end

  assert_space_held_R3: assert property (@(posedge clk) disable iff (rst)
    (wrSeen != '0) |-> txSpace);

  assert_avail_held_R6: assert property (@(posedge clk) disable iff (rst)
    (rdSeen != '0) |-> rxPktAvail);

  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    overrunErr |=> overrunErr);

  assert_overrun_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (liveCycle && $rose(overrunErr)) |-> $past(busWrStb && !txSpace));

  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    underrunErr |=> underrunErr);

  assert_ts_step_R10: assert property (@(posedge clk) disable iff (rst)
    liveCycle |-> (timestamp == $past(timestamp) + 1'b1));
endmodule

bind host_pkt_bridge host_pkt_bridge_chk #(.PKT_WORDS(PKT_WORDS), .TS_W(TS_W)) uChk (
  .clk         (clk),
  .rst         (rst),
  .busWrStb    (busWrStb),
  .busRdStb    (busRdStb),
  .txSpace     (txSpace),
  .rxPktAvail  (rxPktAvail),
  .overrunErr  (overrunErr),
  .underrunErr (underrunErr),
  .timestamp   (timestamp)
);

// File: tb/tb_host_pkt_bridge.sv
module tb_host_pkt_bridge;
  localparam int DW  = 16;
  localparam int PKT = 256;
  localparam int NCH = 2;
  localparam int TXD = 2 * PKT;
  localparam int RXD = 2 * PKT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busWrStb = 1'b0, busRdStb = 1'b0, rxWrEn = 1'b0;
  logic [DW-1:0] busWrData = '0, rxWrData = '0;
  logic [NCH-1:0] txRdEn = '0;
  logic txSpace, rxPktAvail, rxFull, overrunErr, underrunErr;
  logic [DW-1:0] busRdData;
  logic [NCH*DW-1:0] txRdData;
  logic [NCH-1:0] txRdValid;
  logic [31:0] timestamp;

  host_pkt_bridge dut (
    .clk(clk), .rst(rst), .busWrStb(busWrStb), .busWrData(busWrData), .txSpace(txSpace),
    .busRdStb(busRdStb), .busRdData(busRdData), .rxPktAvail(rxPktAvail),
    .txRdEn(txRdEn), .txRdData(txRdData), .txRdValid(txRdValid),
    .rxWrEn(rxWrEn), .rxWrData(rxWrData), .rxFull(rxFull),
    .overrunErr(overrunErr), .underrunErr(underrunErr), .timestamp(timestamp)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  // Bench model of the requirements.
  logic [DW-1:0] mTx [NCH][$];
  logic [DW-1:0] mRx [$];
  int mTxCh, mTxPos, mRxPos;
  bit mOver, mUnder;
  logic [31:0] mTs;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expSpace();
    return (mTxPos != 0) || (mTx[mTxCh].size() <= TXD - PKT);
  endfunction

  function automatic bit expAvail();
    return (mRxPos != 0) || (mRx.size() >= PKT);
  endfunction

  task automatic modelReset();
    for (int c = 0; c < NCH; c++) mTx[c].delete();
    mRx.delete();
    mTxCh = 0; mTxPos = 0; mRxPos = 0; mOver = 0; mUnder = 0; mTs = 0;
  endtask

  task automatic checkAll();
    check("R3 txSpace", {31'd0, txSpace}, {31'd0, expSpace()});
    check("R6 rxPktAvail", {31'd0, rxPktAvail}, {31'd0, expAvail()});
    check("R4 overrunErr", {31'd0, overrunErr}, {31'd0, mOver});
    check("R7 underrunErr", {31'd0, underrunErr}, {31'd0, mUnder});
    check("R9 rxFull", {31'd0, rxFull}, {31'd0, mRx.size() == RXD});
    check("R10 timestamp", timestamp, mTs);
    if (mRx.size() > 0) check("R8 busRdData", {16'd0, busRdData}, {16'd0, mRx[0]});
    for (int c = 0; c < NCH; c++) begin
      check("R5 txRdValid", {31'd0, txRdValid[c]}, {31'd0, mTx[c].size() > 0});
      if (mTx[c].size() > 0)
        check("R2/R5 txRdData", {16'd0, txRdData[c*DW +: DW]}, {16'd0, mTx[c][0]});
    end
  endtask

  // One clock: check current outputs, apply inputs, advance model, wait past edge.
  task automatic cycle(input bit wr, input logic [DW-1:0] wd, input bit rd,
                       input logic [NCH-1:0] pops, input bit rw, input logic [DW-1:0] rwd);
    bit sp, av;
    int rxSz;
    checkAll();
    busWrStb = wr; busWrData = wd; busRdStb = rd; txRdEn = pops; rxWrEn = rw; rxWrData = rwd;
    sp = expSpace(); av = expAvail(); rxSz = mRx.size();
    for (int c = 0; c < NCH; c++)
      if (pops[c] && mTx[c].size() > 0) void'(mTx[c].pop_front());
    if (wr) begin
      if (sp) begin
        mTx[mTxCh].push_back(wd);
        mTxPos++;
        if (mTxPos == PKT) begin mTxPos = 0; mTxCh = (mTxCh + 1) % NCH; end
      end else mOver = 1;
    end
    if (rd) begin
      if (av) begin
        void'(mRx.pop_front());
        mRxPos = (mRxPos + 1) % PKT;
      end else mUnder = 1;
    end
    if (rw && rxSz < RXD) mRx.push_back(rwd);
    mTs++;
    @(posedge clk); #1;
    busWrStb = 0; busRdStb = 0; txRdEn = '0; rxWrEn = 0;
  endtask

  task automatic doReset();
    rst = 1;
    busWrStb = 0; busRdStb = 0; txRdEn = '0; rxWrEn = 0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 0;
    modelReset();
  endtask

  task automatic writePkt(input int tag);
    for (int w = 0; w < PKT; w++) cycle(1, {tag[7:0], w[7:0]}, 0, '0, 0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20070323));
    modelReset();
    doReset();

    // R1: state straight after reset.
    check("R1 txSpace", {31'd0, txSpace}, 32'd1);
    check("R1 rxPktAvail", {31'd0, rxPktAvail}, 32'd0);
    check("R1 errors", {30'd0, overrunErr, underrunErr}, 32'd0);
    check("R1 txRdValid", {30'd0, txRdValid}, 32'd0);
    check("R1 rxFull", {31'd0, rxFull}, 32'd0);
    check("R1 timestamp", timestamp, 32'd0);

    // R2: four packets alternate channels; both FIFOs end full.
    for (int p = 0; p < 4; p++) writePkt(p);
    check("R2 ch0 head from packet 0", {16'd0, txRdData[DW-1:0]}, 32'h0000);
    check("R2 ch1 head from packet 1", {16'd0, txRdData[2*DW-1:DW]}, 32'h0100);
    check("R3 space withheld when channel 0 full", {31'd0, txSpace}, 32'd0);

    // R4: rejected write leaves data and position unchanged.
    cycle(1, 16'hDEAD, 0, '0, 0, '0);
    check("R4 overrun set", {31'd0, overrunErr}, 32'd1);
    check("R4 ch0 head unchanged", {16'd0, txRdData[DW-1:0]}, 32'h0000);

    // R3: 255 free words is not enough, 256 is.
    for (int i = 0; i < PKT - 1; i++) cycle(0, '0, 0, 2'b01, 0, '0);
    check("R3 255 free still blocked", {31'd0, txSpace}, 32'd0);
    cycle(0, '0, 0, 2'b01, 0, '0);
    check("R3 256 free grants space", {31'd0, txSpace}, 32'd1);
    // R5: empty-channel pops ignored after draining channel 1.
    for (int i = 0; i < TXD + 4; i++) cycle(0, '0, 0, 2'b10, 0, '0);
    check("R5 ch1 empty", {31'd0, txRdValid[1]}, 32'd0);

    // R6/R7: receive packet threshold.
    for (int i = 0; i < PKT - 1; i++) cycle(0, '0, 0, '0, 1, 16'h4000 + 16'(i));
    check("R6 255 words not a packet", {31'd0, rxPktAvail}, 32'd0);
    cycle(0, '0, 1, '0, 0, '0);
    check("R7 underrun set", {31'd0, underrunErr}, 32'd1);
    check("R7 head unchanged", {16'd0, busRdData}, 32'h4000);
    cycle(0, '0, 0, '0, 1, 16'h40FF);
    check("R6 packet available", {31'd0, rxPktAvail}, 32'd1);
    for (int i = 0; i < PKT; i++) cycle(0, '0, 1, '0, 0, '0);
    check("R6 drops after last word", {31'd0, rxPktAvail}, 32'd0);

    // R9: fill receive FIFO, extra push ignored.
    for (int i = 0; i < RXD + 3; i++) cycle(0, '0, 0, '0, 1, 16'h8000 + 16'(i));
    check("R9 rxFull", {31'd0, rxFull}, 32'd1);
    for (int i = 0; i < PKT; i++) cycle(0, '0, 1, '0, 0, '0);
    check("R6 second packet still held", {31'd0, rxPktAvail}, 32'd1);
    check("R8 order after full", {16'd0, busRdData}, 32'h8100);

    // Random traffic at several rate mixes.
    doReset();
    for (int phase = 0; phase < 3; phase++) begin
      int wp, rp, pp, xp;
      wp = (phase == 0) ? 70 : (phase == 1) ? 30 : 90;
      rp = (phase == 0) ? 40 : (phase == 1) ? 80 : 20;
      pp = (phase == 0) ? 40 : (phase == 1) ? 70 : 15;
      xp = (phase == 0) ? 50 : (phase == 1) ? 20 : 85;
      for (int i = 0; i < 12000; i++) begin
        logic [NCH-1:0] pops;
        for (int c = 0; c < NCH; c++) pops[c] = (($urandom % 100) < pp);
        cycle(($urandom % 100) < wp, 16'($urandom), ($urandom % 100) < rp, pops,
              ($urandom % 100) < xp, 16'($urandom));
      end
    end

    // R11: reset mid-packet, then first packet returns to channel 0.
    for (int w = 0; w < 10; w++) cycle(1, 16'h7700 + 16'(w), 0, '0, 1, 16'h1234);
    doReset();
    check("R11 errors cleared", {30'd0, overrunErr, underrunErr}, 32'd0);
    check("R11 tx empty", {30'd0, txRdValid}, 32'd0);
    check("R11 rx no packet", {31'd0, rxPktAvail}, 32'd0);
    writePkt(8'h55);
    check("R11 restart on channel 0", {16'd0, txRdData[DW-1:0]}, 32'h5500);
    check("R11 channel 1 untouched", {31'd0, txRdValid[1]}, 32'd0);
    checkAll();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule